// File: doc/BRIEF.md
# Nickel-and-Dime Vending Controller

This block controls a release latch for one product that costs 15 cents. A coin sensor presents a one-cycle strobe for each nickel or dime it accepts. The controller adds up credit in 5-cent steps and stops at a full 15-cent level. Any payment above the price is kept and no change is returned. The full level holds until reset. A single output tells the release mechanism to open.

The timing of that output is fixed at build time by a parameter, and three styles are offered. A Moore stage decodes the full credit level, so the output follows the state register. A combinational Mealy stage also raises the output in the same cycle as the coin that completes payment. A registered Mealy stage captures the Mealy value in a flip-flop. Its output then changes only at a clock edge, one cycle after the combinational version, and cannot glitch.

The coin strobes and the open signal are plain control pins, sampled on every clock. They have no handshake and no back-pressure. The sensor must not present a coin while reset is high, because such a coin is lost.

Top module: `coin_vend_ctrl`

## Requirements
- R1: A synchronous, active-high reset returns credit to 0 cents. In the first cycle after reset, with no coin applied, open is low in every style.
- R2: Credit is kept as a 2-bit code: 00 means 0 cents, 01 means 5, 10 means 10 and 11 means 15. A lone nickel strobe adds one step and a lone dime strobe adds two steps, and the sum is capped at 11.
- R3: In a cycle with neither strobe high, credit keeps its value.
- R4: A dime at 10 cents moves credit to 15 cents. The extra 5 cents is absorbed, and the machine behaves exactly as if 15 cents had been paid.
- R5: Once credit reaches 15 cents it stays there, whatever the strobes do, until reset.
- R6: Both strobes high in the same cycle count as no coin: credit does not change and open is not raised by that cycle.
- R7: Moore style (STYLE = OUT_MOORE): open is high exactly in the cycles in which credit is 15 cents.
- R8: Combinational Mealy style (STYLE = OUT_MEALY): open is high while credit is 15 cents. It is also high in the same cycle as a coin that completes payment, which is a nickel at 10 cents or a dime at 5 or 10 cents.
- R9: Registered Mealy style (STYLE = OUT_MEALY_REG): open equals the combinational Mealy value of the previous cycle, and is low in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| nickel_i | input | 1 | One-cycle strobe: a 5-cent coin was accepted |
| dime_i | input | 1 | One-cycle strobe: a 10-cent coin was accepted |
| open_o | output | 1 | Release command to the dispensing mechanism |

## Verification
Two things can land in the same cycle: a coin that completes payment and the raising of open. In combinational Mealy style both happen in that one cycle, and in registered Mealy style open rises one cycle later. The bench provokes this with nickel-nickel-nickel, nickel-dime, dime-dime and the 20-cent case dime-then-dime-from-10. It runs all three styles side by side on the same strobes and compares each output with a reference model in the cycle of the coin and in the cycle after. Simultaneous strobes and coins applied after the full level are fed through the same scoreboard, which shows that neither credit nor open moves.

// File: rtl/vend_pkg.sv
package vend_pkg;
  localparam int CREDIT_W     = 2;
  localparam int NICKEL_STEPS = 1;
  localparam int DIME_STEPS   = 2;
  localparam int SUM_W        = CREDIT_W + 1;

  typedef enum logic [CREDIT_W-1:0] {
    CR_0  = 2'b00,
    CR_5  = 2'b01,
    CR_10 = 2'b10,
    CR_15 = 2'b11
  } credit_e;

  typedef enum logic [1:0] {
    OUT_MOORE     = 2'd0,
    OUT_MEALY     = 2'd1,
    OUT_MEALY_REG = 2'd2
  } out_style_e;
endpackage

// File: rtl/vend_credit_next.sv
module vend_credit_next
  import vend_pkg::*;
(
  input  credit_e cur_i,
  input  logic    nickel_i,
  input  logic    dime_i,
  output credit_e nxt_o
);
  localparam logic [SUM_W-1:0] FULL_SUM = SUM_W'(CR_15);

  logic [SUM_W-1:0] steps;
  logic [SUM_W-1:0] sum;

  // Exactly one strobe counts as a coin; both together count as none (R6)
  always_comb begin
    steps = '0;
    if (nickel_i && !dime_i) steps = SUM_W'(NICKEL_STEPS);
    if (dime_i && !nickel_i) steps = SUM_W'(DIME_STEPS);
    sum = {1'b0, cur_i} + steps;
    if (cur_i == CR_15 || sum >= FULL_SUM) nxt_o = CR_15;  // R4, R5 saturation
    else                                   nxt_o = credit_e'(sum[CREDIT_W-1:0]);
  end
endmodule

// File: rtl/vend_credit_reg.sv
module vend_credit_reg
  import vend_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    nickel_i,
  input  logic    dime_i,
  input  credit_e nxt_i,
  output credit_e cur_o
);
  always_ff @(posedge clk) begin
    if (rst) cur_o <= CR_0;
    else     cur_o <= nxt_i;
  end

  p_reset_zero_r1: assert property (@(posedge clk) rst |=> cur_o == CR_0);
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!nickel_i && !dime_i) |=> $stable(cur_o));
  p_dime_ten_r4: assert property (@(posedge clk) disable iff (rst)
    (cur_o == CR_10 && dime_i && !nickel_i) |=> cur_o == CR_15);
  p_full_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    cur_o == CR_15 |=> cur_o == CR_15);
  p_both_noop_r6: assert property (@(posedge clk) disable iff (rst)
    (nickel_i && dime_i) |=> $stable(cur_o));
  p_nickel_step_r2: assert property (@(posedge clk) disable iff (rst)
    (cur_o == CR_0 && nickel_i && !dime_i) |=> cur_o == CR_5);
endmodule

// File: rtl/vend_open_stage.sv
module vend_open_stage
  import vend_pkg::*;
#(
  parameter out_style_e STYLE = OUT_MOORE
) (
  input  logic    clk,
  input  logic    rst,
  input  credit_e cur_i,
  input  credit_e nxt_i,
  output logic    open_o
);
  logic mealy_open;
  assign mealy_open = (cur_i == CR_15) || (nxt_i == CR_15);

  generate
    if (STYLE == OUT_MOORE) begin : g_moore
      assign open_o = (cur_i == CR_15);
      p_moore_lag_r7: assert property (@(posedge clk) disable iff (rst)
        (nxt_i == CR_15) |=> open_o);
    end else if (STYLE == OUT_MEALY) begin : g_mealy
      assign open_o = mealy_open;
      p_mealy_early_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(open_o) |-> cur_i != CR_15);
    end else begin : g_mealy_reg
      logic open_q;
      always_ff @(posedge clk) begin
        if (rst) open_q <= 1'b0;
        else     open_q <= mealy_open;
      end
      assign open_o = open_q;
      p_reg_full_r9: assert property (@(posedge clk) disable iff (rst)
        open_o |-> cur_i == CR_15);
    end
  endgenerate
endmodule

// File: rtl/coin_vend_ctrl.sv
module coin_vend_ctrl
  import vend_pkg::*;
#(
  parameter out_style_e STYLE = OUT_MOORE
) (
  input  logic clk,
  input  logic rst,
  input  logic nickel_i,
  input  logic dime_i,
  output logic open_o
);
  credit_e cur;
  credit_e nxt;

  vend_credit_next u_next (
    .cur_i    (cur),
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .nxt_o    (nxt)
  );

  vend_credit_reg u_state (
    .clk      (clk),
    .rst      (rst),
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .nxt_i    (nxt),
    .cur_o    (cur)
  );

  vend_open_stage #(.STYLE(STYLE)) u_open (
    .clk    (clk),
    .rst    (rst),
    .cur_i  (cur),
    .nxt_i  (nxt),
    .open_o (open_o)
  );

  // Full credit always drives open in every style (R7, R8, R9)
  p_full_opens_r7: assert property (@(posedge clk) disable iff (rst)
    cur == CR_15 |-> open_o);
endmodule

// File: tb/coin_vend_ctrl_tb.sv
module coin_vend_ctrl_tb;
  import vend_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickel = 1'b0;
  logic dime = 1'b0;
  logic open_moore, open_mealy, open_reg;

  always #2.5 clk = ~clk;  // 200 MHz

  coin_vend_ctrl #(.STYLE(OUT_MOORE)) u_dut (
    .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .open_o(open_moore));
  coin_vend_ctrl #(.STYLE(OUT_MEALY)) u_dut_mealy (
    .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .open_o(open_mealy));
  coin_vend_ctrl #(.STYLE(OUT_MEALY_REG)) u_dut_reg (
    .clk(clk), .rst(rst), .nickel_i(nickel), .dime_i(dime), .open_o(open_reg));

  typedef struct packed { logic moore; logic mealy; logic rg; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];
  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;

  // reference model
  int cred = 0;
  bit reg_prev = 1'b0;

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; nickel = 1'b0; dime = 1'b0;
    cred = 0; reg_prev = 1'b0;
  endtask

  task automatic coin(input bit n, input bit d, input string tag);
    int   inc;
    bit   full;
    exp_t e;
    @(negedge clk);
    rst = 1'b0; nickel = n; dime = d;
    inc  = (n && !d) ? 1 : ((d && !n) ? 2 : 0);
    full = (cred == 3);
    e.moore = full;
    e.mealy = full || (inc != 0 && cred + inc >= 3);
    e.rg    = reg_prev;
    reg_prev = e.mealy;
    cred = full ? 3 : ((cred + inc > 3) ? 3 : cred + inc);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic cmp(input string tag, input string mode, input logic act, input logic ex);
    vectors++;
    if (act !== ex) begin
      miscompares++;
      $display("FAIL %s %s: open actual %b expected %b", tag, mode, act, ex);
    end
  endtask

  // monitor: pops one expectation per driven cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        cmp({t, "/R7"}, "moore", open_moore, e.moore);
        cmp({t, "/R8"}, "mealy", open_mealy, e.mealy);
        cmp({t, "/R9"}, "mealy_reg", open_reg, e.rg);
      end
    end
  end

  initial begin
    do_reset();
    coin(0, 0, "R1 idle after reset");
    // R2 nickel x3, then R5 coins after full
    coin(1, 0, "R2 n1"); coin(0, 0, "R3 hold 5"); coin(1, 0, "R2 n2");
    coin(1, 0, "R2 n3 completes"); coin(0, 0, "R5 full idle");
    coin(1, 0, "R5 nickel after full"); coin(0, 1, "R5 dime after full");
    coin(1, 1, "R5 both after full"); coin(0, 0, "R5 still full");
    do_reset();
    coin(0, 0, "R1 reset clears full"); coin(0, 0, "R1 idle");
    // nickel-dime
    coin(1, 0, "R2 n"); coin(0, 1, "R8 dime at 5 completes"); coin(0, 0, "R5 hold");
    do_reset();
    // dime-dime
    coin(0, 1, "R2 d"); coin(0, 0, "R3 hold 10"); coin(0, 1, "R4 dime at 10");
    coin(0, 1, "R4 overpay absorbed"); coin(0, 0, "R4 hold");
    do_reset();
    // simultaneous strobes ignored
    coin(0, 1, "R2 d"); coin(1, 1, "R6 both at 10"); coin(0, 0, "R6 no change");
    coin(1, 0, "R6 nickel shows 10 kept"); coin(0, 0, "R5 hold");
    do_reset();
    coin(1, 1, "R6 both at 0"); coin(1, 1, "R6 both again");
    coin(0, 1, "R6 dime shows 0 kept"); coin(0, 0, "R3 hold 10");
    coin(1, 0, "R8 nickel at 10 completes"); coin(0, 0, "R9 reg follows");
    // reset in mid-credit
    do_reset();
    coin(1, 0, "R2 n"); coin(0, 0, "R3 hold");
    do_reset();
    coin(0, 0, "R1 mid-credit reset"); coin(0, 1, "R2 d from 0");
    coin(1, 0, "R8 nickel at 10"); coin(0, 0, "R9 hold");
    @(negedge clk); nickel = 1'b0; dime = 1'b0;
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule